// File: doc/BRIEF.md
# Single-Wire Bus Yield Arbiter

This block lets other bus masters borrow the local bus from the processor's bus sequencer. Each channel is one shared, active-low wire. Another master asks for the bus with a one-clock low pulse. The arbiter answers with its own one-clock low pulse when the bus may be handed over. The master later gives the bus back with a third one-clock pulse. On the chip, each wire is split into a sampled input and a driven output. The output is high when the arbiter does not drive.

The arbiter watches the sequencer's phase code and its cycle qualifiers:
- the low byte of a word at an odd address,
- the first of a pair of interrupt acknowledges,
- a locked instruction in progress.

From these it decides in which clock the bus may be handed over. While another master owns the bus, the arbiter raises a hold-acknowledge flag and reports the owning channel. The bus sequencer uses this flag to float its bus. After every exchange one dead clock passes before another grant. Lower-numbered channels win over higher-numbered ones.

Top module: `yield_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every grant output is high and `hold_ack` is low.
- R2: A request pulse seen in a clock with phase code 0 (idle) produces a grant in the next clock, if nothing blocks it. The grant is a low level for exactly one clock on that channel's `line_out_n`.
- R3: `hold_ack` rises in the clock after a grant and stays high until a release. No grant is driven while it is high. `hold_owner` gives the index of the granted channel.
- R4: A release pulse from the owning channel in clock m makes `hold_ack` low from clock m+1.
- R5: In the clock right after `hold_ack` falls, no grant is driven, even when a request is pending and the bus is idle. A pending request may be granted in the clock after that.
- R6: Phase codes are 0 idle, 1 T1, 2 T2, 3 T3, 4 wait state, 5 T4. Codes 6 and 7 behave like T3. During a bus cycle, a grant is driven only in a T4 clock. A request first seen in T1 or T2 of a cycle is granted in that cycle's T4 when nothing else blocks it.
- R7: A request first seen in T3 or in a wait state is not granted in the T4 of the same cycle. It is granted in the T4 of the following bus cycle.
- R8: A T4 in which `odd_low_byte` or `ack_first` is high gives no grant. The request stays pending and is granted in a later T4 that is not blocked.
- R9: While `locked` is high, no grant is driven in any phase. Pending requests survive and are granted once `locked` falls.
- R10: When several channels are pending, the lowest-numbered channel is granted first. A higher channel is served only after the lower channel's exchange and the dead clock.
- R11: The arbiter's own grant pulse, seen back on the shared wire, does not count as a new request. After a completed exchange with no new request pulse, no further grant appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_in_n | input | N_CH | Sampled level of each request/grant wire, active low |
| line_out_n | output | N_CH | Grant drive for each wire, low for one clock to grant |
| bus_phase | input | 3 | Phase code of the current bus clock (0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4) |
| odd_low_byte | input | 1 | The current cycle is the low byte of a word at an odd address |
| ack_first | input | 1 | The current cycle is the first of an interrupt-acknowledge pair |
| locked | input | 1 | A locked instruction is executing |
| hold_ack | output | 1 | Another master owns the bus |
| hold_owner | output | OW | Index of the channel that owns the bus |

## Verification
The bench drives four situations and checks the grant timing in each:
- A request in T3. A design that only remembers "request pending" would grant in that same T4.
- A T4 blocked by an odd-address low byte or a first interrupt acknowledge. A design that drops the request instead of keeping it pending would never grant.
- A request that is pending when the owner releases. A design that skips the dead clock would grant one clock early.
- Simultaneous requests. These expose inverted priority.

A long random run uses realistic bus-cycle sequences, wait states, locks and releases. It compares every clock against a bench model. This catches a grant that re-triggers from the arbiter's own pulse on the wire.

// File: rtl/yield_arbiter.sv
module yield_arbiter #(
  parameter int N_CH = 2,
  localparam int OW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] line_in_n,
  output logic [N_CH-1:0] line_out_n,
  input  logic [2:0]      bus_phase,
  input  logic            odd_low_byte,
  input  logic            ack_first,
  input  logic            locked,
  output logic            hold_ack,
  output logic [OW-1:0]   hold_owner
);

  typedef enum logic [1:0] {S_FREE, S_HELD, S_DEAD} st_t;

  localparam logic [2:0] PH_IDLE = 3'd0;
  localparam logic [2:0] PH_T3   = 3'd3;
  localparam logic [2:0] PH_TW   = 3'd4;
  localparam logic [2:0] PH_T4   = 3'd5;

  st_t             st;
  logic [N_CH-1:0] pend;
  logic [N_CH-1:0] early;
  logic [OW-1:0]   sel;
  logic            any_pend;
  logic            grant_ok;
  logic            ph_idle, ph_t4, ph_late;

  assign ph_idle = (bus_phase == PH_IDLE);
  assign ph_t4   = (bus_phase == PH_T4);
  assign ph_late = (bus_phase == PH_T3) || (bus_phase == PH_TW) || (bus_phase > PH_T4);

  always_comb begin
    sel      = '0;
    any_pend = 1'b0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (pend[i]) begin
        sel      = OW'(i);
        any_pend = 1'b1;
      end
    end
  end

  assign grant_ok = (st == S_FREE) && any_pend && !locked &&
                    (ph_idle || (ph_t4 && early[sel] && !odd_low_byte && !ack_first));

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic mine, cap, p_q, e_q;
    assign mine = (sel == OW'(i));
    assign line_out_n[i] = ~(grant_ok & mine);
    assign cap = ~line_in_n[i] & ~p_q & ~((st == S_HELD) && (hold_owner == OW'(i)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        p_q <= 1'b0;
        e_q <= 1'b0;
      end else if (grant_ok && mine) begin
        p_q <= 1'b0;
      end else if (cap) begin
        p_q <= 1'b1;
        e_q <= ~ph_late;
      end else if (p_q && ph_t4) begin
        e_q <= 1'b1;
      end
    end

    assign pend[i]  = p_q;
    assign early[i] = e_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_FREE;
      hold_owner <= '0;
    end else begin
      case (st)
        S_FREE: if (grant_ok) begin
          st         <= S_HELD;
          hold_owner <= sel;
        end
        S_HELD: if (!line_in_n[hold_owner]) st <= S_DEAD;
        default: st <= S_FREE;
      endcase
    end
  end

  assign hold_ack = (st == S_HELD);

endmodule

// File: rtl/yield_arbiter_props.sv
module yield_arbiter_props #(
  parameter int N_CH = 2,
  parameter int OW = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_CH-1:0] line_in_n,
  input logic [N_CH-1:0] line_out_n,
  input logic [2:0]      bus_phase,
  input logic            odd_low_byte,
  input logic            ack_first,
  input logic            locked,
  input logic            hold_ack,
  input logic [OW-1:0]   hold_owner
);

  logic granting;
  assign granting = (line_out_n != {N_CH{1'b1}});

  assert_grant_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    granting |-> (bus_phase == 3'd0 || bus_phase == 3'd5));

  assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~line_out_n));

  assert_hold_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    granting |=> hold_ack);

  assert_hold_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(granting));

  assert_quiet_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> !granting);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !line_in_n[hold_owner]) |=> !hold_ack);

  assert_dead_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_ack) |-> !granting);

  assert_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !granting);

  assert_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_phase == 3'd5 && (odd_low_byte || ack_first)) |-> !granting);

endmodule

bind yield_arbiter yield_arbiter_props #(.N_CH(N_CH), .OW(OW)) u_props (
  .clk(clk), .rst_n(rst_n), .line_in_n(line_in_n), .line_out_n(line_out_n),
  .bus_phase(bus_phase), .odd_low_byte(odd_low_byte), .ack_first(ack_first),
  .locked(locked), .hold_ack(hold_ack), .hold_owner(hold_owner)
);

// File: tb/yield_arbiter_test.sv
module yield_arbiter_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic [1:0] m_n = 2'b11;
  logic [2:0] phase = 3'd0;
  logic       odd = 1'b0, ackf = 1'b0, lk = 1'b0;
  logic [1:0] out_n;
  logic [1:0] line_n;
  logic       hold_ack;
  logic [0:0] owner;

  assign line_n = m_n & out_n;

  yield_arbiter uut (
    .clk(clk), .rst_n(rst_n), .line_in_n(line_n), .line_out_n(out_n),
    .bus_phase(phase), .odd_low_byte(odd), .ack_first(ackf), .locked(lk),
    .hold_ack(hold_ack), .hold_owner(owner)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur = "R1";

  // reference model: 0 free, 1 held, 2 dead
  int ms = 0;
  bit [1:0] mp = 2'b00, me = 2'b00;
  bit mo = 0;

  function automatic bit elig(input bit e);
    return !lk && (phase == 3'd0 || (phase == 3'd5 && e && !odd && !ackf));
  endfunction

  function automatic logic [1:0] exp_grant();
    logic [1:0] g = 2'b00;
    if (ms == 0) begin
      if (mp[0]) g[0] = elig(me[0]);
      else if (mp[1]) g[1] = elig(me[1]);
    end
    return g;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mp = 2'b00; me = 2'b00; mo = 0;
    end else begin
      logic [1:0] g;
      int nms;
      g = exp_grant();
      nms = ms;
      if (ms == 0 && g != 2'b00) begin nms = 1; mo = g[1] & !g[0]; end
      else if (ms == 1 && !m_n[mo]) nms = 2;
      else if (ms == 2) nms = 0;
      for (int i = 0; i < 2; i++) begin
        if (g[i]) mp[i] = 0;
        else if (!m_n[i] && !mp[i] && !(ms == 1 && mo == i)) begin
          mp[i] = 1;
          me[i] = !(phase == 3'd3 || phase == 3'd4 || phase > 3'd5);
        end else if (mp[i] && phase == 3'd5) me[i] = 1;
      end
      ms = nms;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] ph, input logic r0, input logic r1,
                      input logic o, input logic a, input logic l);
    @(posedge clk); #1;
    phase = ph; m_n = {~r1, ~r0}; odd = o; ackf = a; lk = l;
    @(negedge clk);
    chk(cur, {30'd0, out_n}, {30'd0, ~exp_grant()});
    chk(cur, {31'd0, hold_ack}, {31'd0, ms == 1});
    if (ms == 1) chk("R3", {31'd0, owner}, {31'd0, mo});
  endtask

  task automatic idle(input logic r0, input logic r1);
    step(3'd0, r0, r1, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    chk("R1", {30'd0, out_n}, 32'h3);
    chk("R1", {31'd0, hold_ack}, 32'h0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {29'd0, out_n, hold_ack}, 32'h6);

    // R2/R3/R4/R11: idle handshake on channel 0
    cur = "R2";
    idle(1, 0);
    chk("R2", {30'd0, out_n}, 32'h3);
    idle(0, 0);
    chk("R2", {30'd0, out_n}, 32'h2);
    cur = "R3";
    idle(0, 0);
    chk("R3", {31'd0, hold_ack}, 32'h1);
    idle(0, 0);
    chk("R3", {30'd0, out_n, owner}, 32'h6);
    cur = "R4";
    idle(1, 0);
    chk("R4", {31'd0, hold_ack}, 32'h1);
    idle(0, 0);
    chk("R4", {31'd0, hold_ack}, 32'h0);
    cur = "R11";
    repeat (4) idle(0, 0);
    chk("R11", {29'd0, out_n, hold_ack}, 32'h6);

    // R5: channel 1 pends during ownership, dead clock honoured
    cur = "R5";
    idle(1, 0); idle(0, 0); idle(0, 1); idle(0, 0);
    idle(1, 0);
    idle(0, 0);
    chk("R5", {29'd0, out_n, hold_ack}, 32'h6);
    idle(0, 0);
    chk("R5", {30'd0, out_n}, 32'h1);
    idle(0, 0);
    chk("R5", {30'd0, hold_ack, owner}, 32'h3);
    idle(0, 1); idle(0, 0); idle(0, 0);

    // R10: simultaneous requests
    cur = "R10";
    idle(1, 1);
    idle(0, 0);
    chk("R10", {30'd0, out_n}, 32'h2);
    idle(0, 0); idle(1, 0); idle(0, 0);
    idle(0, 0);
    chk("R10", {30'd0, out_n}, 32'h1);
    idle(0, 0); idle(0, 1); idle(0, 0); idle(0, 0);

    // R6: early request in T1
    cur = "R6";
    step(3'd1, 1, 0, 0, 0, 0);
    step(3'd2, 0, 0, 0, 0, 0);
    chk("R6", {30'd0, out_n}, 32'h3);
    step(3'd3, 0, 0, 0, 0, 0);
    step(3'd5, 0, 0, 0, 0, 0);
    chk("R6", {30'd0, out_n}, 32'h2);
    idle(0, 0); idle(1, 0); idle(0, 0); idle(0, 0);

    // R7: late request in T3
    cur = "R7";
    step(3'd1, 0, 0, 0, 0, 0);
    step(3'd2, 0, 0, 0, 0, 0);
    step(3'd3, 0, 1, 0, 0, 0);
    step(3'd4, 0, 0, 0, 0, 0);
    step(3'd5, 0, 0, 0, 0, 0);
    chk("R7", {30'd0, out_n}, 32'h3);
    step(3'd1, 0, 0, 0, 0, 0);
    step(3'd2, 0, 0, 0, 0, 0);
    step(3'd3, 0, 0, 0, 0, 0);
    step(3'd5, 0, 0, 0, 0, 0);
    chk("R7", {30'd0, out_n}, 32'h1);
    idle(0, 0); idle(0, 1); idle(0, 0); idle(0, 0);

    // R8: odd low byte, then first acknowledge, block T4
    cur = "R8";
    step(3'd1, 1, 0, 1, 0, 0);
    step(3'd2, 0, 0, 1, 0, 0);
    step(3'd3, 0, 0, 1, 0, 0);
    step(3'd5, 0, 0, 1, 0, 0);
    chk("R8", {30'd0, out_n}, 32'h3);
    step(3'd1, 0, 0, 0, 1, 0);
    step(3'd2, 0, 0, 0, 1, 0);
    step(3'd5, 0, 0, 0, 1, 0);
    chk("R8", {30'd0, out_n}, 32'h3);
    step(3'd1, 0, 0, 0, 0, 0);
    step(3'd5, 0, 0, 0, 0, 0);
    chk("R8", {30'd0, out_n}, 32'h2);
    idle(0, 0); idle(1, 0); idle(0, 0); idle(0, 0);

    // R9: locked instruction
    cur = "R9";
    step(3'd0, 1, 0, 0, 0, 1);
    step(3'd0, 0, 0, 0, 0, 1);
    chk("R9", {30'd0, out_n}, 32'h3);
    step(3'd1, 0, 0, 0, 0, 1);
    step(3'd5, 0, 0, 0, 0, 1);
    chk("R9", {30'd0, out_n}, 32'h3);
    step(3'd0, 0, 0, 0, 0, 0);
    chk("R9", {30'd0, out_n}, 32'h2);
    idle(0, 0); idle(1, 0); idle(0, 0); idle(0, 0);

    // random bus traffic against the model
    cur = "R10";
    begin
      logic [2:0] ph = 3'd0;
      logic l = 0;
      for (int n = 0; n < 4000; n++) begin
        logic r0, r1, o, a;
        case (ph)
          3'd0: ph = ($urandom % 3 == 0) ? 3'd0 : 3'd1;
          3'd1: ph = 3'd2;
          3'd2: ph = 3'd3;
          3'd3: ph = ($urandom % 4 == 0) ? 3'd4 : 3'd5;
          3'd4: ph = ($urandom % 3 == 0) ? 3'd4 : 3'd5;
          default: ph = ($urandom % 2 == 0) ? 3'd1 : 3'd0;
        endcase
        if ($urandom % 20 == 0) l = ~l;
        o = ($urandom % 6 == 0);
        a = ($urandom % 6 == 0);
        r0 = (ms == 1 && mo == 0) ? ($urandom % 4 == 0) : ($urandom % 12 == 0);
        r1 = (ms == 1 && mo == 1) ? ($urandom % 4 == 0) : ($urandom % 12 == 0);
        step(ph, r0, r1, o, a, l);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule